// File: doc/BRIEF.md
# Base-and-Limit Address Relocation Unit

This block sits on the address path between a processor and its memory and gives each user program a private, contiguous window of physical memory. While the machine is in supervisor mode, every request address goes straight through as the physical address. The supervisor starts a user program with a single privileged command. That command loads a relocation base and a bound in one step and drops the machine into user mode.

In user mode the block checks each request address against the bound before it does anything else. The bound holds the first address that is *not* legal. An address strictly below the bound is relocated by adding the base and is passed on. Any other address is stopped and never reaches memory. The block also stops an address whose relocated value would carry out of the physical width. A stopped access produces a one-cycle violation pulse and sets a sticky "program suspended" flag. It also forces the mode back to supervisor, where the bound and base stop mattering.

The mode is held in a two-state machine. State `ST_SUPER` is the reset state and the pass-through state. State `ST_USER` is the protected state. Transition `ENTER` goes from `ST_SUPER` to `ST_USER` and is taken when `enter_user` is high in supervisor mode. Transition `TRAP` goes from `ST_USER` to `ST_SUPER` and is taken when a request in user mode fails the bound or carry check. Every result is registered, so each request is answered exactly one cycle later.

Top module: `reloc_unit`

## Requirements
- R1: After reset the unit is in supervisor mode (`user_mode`=0), and `phys_valid`, `viol_pulse` and `viol_sticky` are all 0.
- R2: In supervisor mode a request with address A gives `phys_valid`=1 and `phys_addr`=A, zero-extended, on the next cycle. Base and bound have no effect.
- R3: `enter_user` in supervisor mode loads `base_in` and `limit_in` and sets `user_mode`=1 from the next cycle. A request in that same cycle is still handled as a supervisor request.
- R4: `enter_user` in user mode is ignored. Base, bound and mode are unchanged.
- R5: In user mode an address is legal only when it is strictly below the bound. Bound−1 is legal and the bound itself is a violation.
- R6: A legal user request gives `phys_valid`=1 and `phys_addr`=base+address on the next cycle.
- R7: A user request whose base+address does not fit in PW bits is a violation, even when the address is below the bound.
- R8: A violation gives `phys_valid`=0 and `viol_pulse`=1 for exactly one cycle, and `user_mode`=0 on that same cycle.
- R9: `viol_sticky` is set by a violation. It is cleared by `viol_clr` only in supervisor mode, and `viol_clr` in user mode has no effect.
- R10: With `req_valid`=0, `phys_valid` is 0 on the next cycle and `phys_addr` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | AW | Logical request address |
| enter_user | input | 1 | Privileged command: load window, enter user mode |
| base_in | input | PW | Relocation base for the command |
| limit_in | input | AW | Bound (highest legal address + 1) for the command |
| viol_clr | input | 1 | Clears the sticky flag (supervisor only) |
| phys_addr | output | PW | Physical address, registered |
| phys_valid | output | 1 | Physical address is valid this cycle |
| viol_pulse | output | 1 | One-cycle violation interrupt |
| viol_sticky | output | 1 | Program-suspended flag |
| user_mode | output | 1 | 1 in user mode, 0 in supervisor mode |

## Verification
The hardest case to reach from the ports is the carry-out violation. The address has to lie below the bound while base plus address passes the top of the physical space, so the window must be placed at the very end of memory with a bound larger than the space left. The stimulus loads a base of 0xFFFF00 with a bound of 0x200. It then steps from address 0xFF, which lands exactly on the last word, to 0x100, which carries out. A second subtle case is an `enter_user` issued while already in user mode with a much wider bound. This case is shown to have no effect when a following access at the old bound still traps.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
    typedef enum logic {
        ST_SUPER = 1'b0,
        ST_USER  = 1'b1
    } mode_e;
endpackage

// File: rtl/reloc_mode_fsm.sv
module reloc_mode_fsm
    import reloc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enter_user,
    input  logic  trap,
    output mode_e mode,
    output logic  load_en
);
    mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SUPER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SUPER: if (enter_user) state_d = ST_USER;   // ENTER
            ST_USER:  if (trap)       state_d = ST_SUPER;  // TRAP
            default:                  state_d = ST_SUPER;
        endcase
    end

    always_comb begin
        mode    = state_q;
        load_en = (state_q == ST_SUPER) && enter_user;
    end
endmodule

// File: rtl/reloc_window_regs.sv
module reloc_window_regs #(
    parameter int AW = 24,
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [PW-1:0] base_in,
    input  logic [AW-1:0] limit_in,
    output logic [PW-1:0] base_q,
    output logic [AW-1:0] limit_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
        end else if (load_en) begin
            base_q  <= base_in;
            limit_q <= limit_in;
        end
    end
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
    import reloc_pkg::*;
#(
    parameter int AW = 24,
    parameter int PW = 24
) (
    input  mode_e         mode,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] base,
    input  logic [AW-1:0] limit,
    output logic [PW-1:0] phys,
    output logic          fault
);
    localparam int SW = PW + 1;
    logic [SW-1:0] sum;
    logic          beyond;

    always_comb begin
        beyond = (addr >= limit);
        sum    = {1'b0, base} + SW'(addr);
        unique case (mode)
            ST_SUPER: begin
                phys  = PW'(addr);
                fault = 1'b0;
            end
            ST_USER: begin
                phys  = sum[PW-1:0];
                fault = beyond | sum[PW];
            end
            default: begin
                phys  = PW'(addr);
                fault = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/reloc_unit.sv
module reloc_unit
    import reloc_pkg::*;
#(
    parameter int AW = 24,
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          enter_user,
    input  logic [PW-1:0] base_in,
    input  logic [AW-1:0] limit_in,
    input  logic          viol_clr,
    output logic [PW-1:0] phys_addr,
    output logic          phys_valid,
    output logic          viol_pulse,
    output logic          viol_sticky,
    output logic          user_mode
);
    mode_e         mode;
    logic          load_en;
    logic [PW-1:0] base_q;
    logic [AW-1:0] limit_q;
    logic [PW-1:0] phys_d;
    logic          fault;
    logic          trap;

    assign trap      = req_valid & fault;
    assign user_mode = (mode == ST_USER);

    reloc_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enter_user(enter_user),
        .trap(trap), .mode(mode), .load_en(load_en)
    );

    reloc_window_regs #(.AW(AW), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .load_en(load_en),
        .base_in(base_in), .limit_in(limit_in),
        .base_q(base_q), .limit_q(limit_q)
    );

    reloc_xlate #(.AW(AW), .PW(PW)) u_xlate (
        .mode(mode), .addr(req_addr), .base(base_q), .limit(limit_q),
        .phys(phys_d), .fault(fault)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr   <= '0;
            phys_valid  <= 1'b0;
            viol_pulse  <= 1'b0;
            viol_sticky <= 1'b0;
        end else begin
            phys_valid <= req_valid & ~fault;
            viol_pulse <= trap;
            if (req_valid && !fault) phys_addr <= phys_d;
            if (trap)                               viol_sticky <= 1'b1;
            else if (viol_clr && mode == ST_SUPER)  viol_sticky <= 1'b0;
        end
    end
endmodule

// File: rtl/reloc_unit_chk.sv
module reloc_unit_chk #(
    parameter int AW = 24,
    parameter int PW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic          enter_user,
    input logic [PW-1:0] phys_addr,
    input logic          phys_valid,
    input logic          viol_pulse,
    input logic          viol_sticky,
    input logic          user_mode,
    input logic [AW-1:0] limit_q
);
    a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode && req_valid) |=> (phys_valid && phys_addr == PW'($past(req_addr))));
    a_r3_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode && enter_user) |=> user_mode);
    a_r4_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
        user_mode |=> $stable(limit_q));
    a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && req_valid && req_addr >= limit_q) |=> viol_pulse);
    a_r8_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(viol_pulse && phys_valid));
    a_r8_to_super: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> !user_mode);
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        viol_pulse |-> viol_sticky);
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !phys_valid);
endmodule

bind reloc_unit reloc_unit_chk #(.AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .enter_user(enter_user), .phys_addr(phys_addr), .phys_valid(phys_valid),
    .viol_pulse(viol_pulse), .viol_sticky(viol_sticky), .user_mode(user_mode),
    .limit_q(limit_q)
);

// File: tb/sim_reloc_unit.sv
module sim_reloc_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int PW = 24;

    typedef struct packed {
        logic        enter, clr, req;
        logic [23:0] base, limit, addr;
        logic        ev, eviol, est, eu;
        logic [23:0] ea;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        // R2 supervisor bypass
        '{1'b0,1'b0,1'b1, 24'h0,      24'h0,      24'h123456, 1'b1,1'b0,1'b0,1'b0, 24'h123456},
        // R3 enter, R10 no request
        '{1'b1,1'b0,1'b0, 24'h001000, 24'h000100, 24'h0,      1'b0,1'b0,1'b0,1'b1, 24'h123456},
        // R5/R6 limit-1 legal
        '{1'b0,1'b0,1'b1, 24'h0,      24'h0,      24'h0000FF, 1'b1,1'b0,1'b0,1'b1, 24'h0010FF},
        // R6 address zero
        '{1'b0,1'b0,1'b1, 24'h0,      24'h0,      24'h000000, 1'b1,1'b0,1'b0,1'b1, 24'h001000},
        // R4 enter in user ignored
        '{1'b1,1'b0,1'b1, 24'h500000, 24'hFFFFFF, 24'h000010, 1'b1,1'b0,1'b0,1'b1, 24'h001010},
        // R5/R8/R9 address equal to limit traps (old limit kept)
        '{1'b0,1'b0,1'b1, 24'h0,      24'h0,      24'h000100, 1'b0,1'b1,1'b1,1'b0, 24'h001010},
        // R2 bypass after trap
        '{1'b0,1'b0,1'b1, 24'h0,      24'h0,      24'h000100, 1'b1,1'b0,1'b1,1'b0, 24'h000100},
        // R3 same-cycle request handled in supervisor
        '{1'b1,1'b0,1'b1, 24'hFFFF00, 24'h000200, 24'h0000AA, 1'b1,1'b0,1'b1,1'b1, 24'h0000AA},
        // R6 top word, R9 clear ignored in user
        '{1'b0,1'b1,1'b1, 24'h0,      24'h0,      24'h0000FF, 1'b1,1'b0,1'b1,1'b1, 24'hFFFFFF},
        // R7 carry out is a violation
        '{1'b0,1'b0,1'b1, 24'h0,      24'h0,      24'h000100, 1'b0,1'b1,1'b1,1'b0, 24'hFFFFFF},
        // R9 clear in supervisor, R8 pulse gone
        '{1'b0,1'b1,1'b0, 24'h0,      24'h0,      24'h0,      1'b0,1'b0,1'b0,1'b0, 24'hFFFFFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          enter_user = 1'b0;
    logic [PW-1:0] base_in = '0;
    logic [AW-1:0] limit_in = '0;
    logic          viol_clr = 1'b0;
    logic [PW-1:0] phys_addr;
    logic          phys_valid, viol_pulse, viol_sticky, user_mode;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reloc_unit #(.AW(AW), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .enter_user(enter_user), .base_in(base_in), .limit_in(limit_in),
        .viol_clr(viol_clr), .phys_addr(phys_addr), .phys_valid(phys_valid),
        .viol_pulse(viol_pulse), .viol_sticky(viol_sticky), .user_mode(user_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; enter_user = 0; viol_clr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 user_mode", 32'(user_mode), 0);
        chk("R1 phys_valid", 32'(phys_valid), 0);
        chk("R1 viol_pulse", 32'(viol_pulse), 0);
        chk("R1 viol_sticky", 32'(viol_sticky), 0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            enter_user = VEC[i].enter;
            viol_clr   = VEC[i].clr;
            req_valid  = VEC[i].req;
            base_in    = VEC[i].base;
            limit_in   = VEC[i].limit;
            req_addr   = VEC[i].addr;
            @(negedge clk);
            chk($sformatf("R6/R8 vec%0d phys_valid", i), 32'(phys_valid), 32'(VEC[i].ev));
            chk($sformatf("R8 vec%0d viol_pulse", i), 32'(viol_pulse), 32'(VEC[i].eviol));
            chk($sformatf("R9 vec%0d viol_sticky", i), 32'(viol_sticky), 32'(VEC[i].est));
            chk($sformatf("R3 vec%0d user_mode", i), 32'(user_mode), 32'(VEC[i].eu));
            chk($sformatf("R2/R6/R10 vec%0d phys_addr", i), 32'(phys_addr), 32'(VEC[i].ea));
        end

        // R7 corner: base at top, address zero is legal
        idle_inputs();
        enter_user = 1; base_in = 24'hFFFFFF; limit_in = 24'h000010;
        @(negedge clk);
        idle_inputs();
        req_valid = 1; req_addr = 24'h000000;
        @(negedge clk);
        chk("R7 top base addr0 valid", 32'(phys_valid), 1);
        chk("R7 top base addr0 value", 32'(phys_addr), 32'hFFFFFF);
        req_addr = 24'h000001;
        @(negedge clk);
        chk("R7 carry one violation", 32'(viol_pulse), 1);
        chk("R8 back to supervisor", 32'(user_mode), 0);
        idle_inputs();

        // R1 reset from user mode with sticky set
        enter_user = 1; base_in = 24'h000100; limit_in = 24'h000010;
        @(negedge clk);
        idle_inputs();
        chk("R3 entered user", 32'(user_mode), 1);
        rst_n = 0;
        @(negedge clk);
        chk("R1 reset mode", 32'(user_mode), 0);
        chk("R1 reset sticky", 32'(viol_sticky), 0);
        chk("R1 reset valid", 32'(phys_valid), 0);
        rst_n = 1;
        @(negedge clk);

        // R5 with bound zero: every user access traps
        enter_user = 1; base_in = 24'h000000; limit_in = 24'h000000;
        @(negedge clk);
        idle_inputs();
        req_valid = 1; req_addr = 24'h000000;
        @(negedge clk);
        idle_inputs();
        chk("R5 zero bound traps", 32'(viol_pulse), 1);
        @(negedge clk);
        chk("R8 pulse single cycle", 32'(viol_pulse), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule